// File: doc/BRIEF.md
# Supply-Pulse Programming Decoder

This block turns a timed series of supply-level codes into writes to a small calibration register and a set of one-time fuse bits. Before it, an analog front end reduces the supply rail to one of four codes: zero, low, mid and high. Each clock cycle counts as one timebase tick. The decoder measures how long each mid and high pulse lasts. It accepts a keyed unlock sequence, counts the mid pulses that follow it as an address, and then acts on the pulse that closes the sequence. A short high pulse loads the count as a trial calibration value. A long high pulse blows the fuse that the count selects.

The trial value lives in a provisional register that is lost whenever the supply falls to zero. Fuse bits are modelled as sticky flops, and reset is the only thing that clears them. Address one past the last code bit is the lock fuse. Once it is blown, no sequence has any effect. The effective calibration code is the OR of the fuse bits and the provisional register.

Top module: `sup_prog_decoder`

## Requirements
- R1: After reset, `code_o` is 0 and `locked_o` is 0.
- R2: `level_i` encodes 0 = zero, 1 = low, 2 = mid, 3 = high. A pulse's length is the number of clock cycles it is present. A mid or high pulse shorter than `MIN_TICKS` is malformed and returns the decoder to idle. A high pulse of `MIN_TICKS` up to `LONG_TICKS`-1 cycles is short, and one of `LONG_TICKS` or more cycles is long.
- R3: Addressing is entered only after a short high pulse, then one mid pulse, then a short high pulse, in that order. Any other pulse during this key returns the decoder to idle.
- R4: After the key, the address equals the number of mid pulses that follow.
- R5: A short high pulse after k mid pulses, with 1 <= k <= 31, loads k into the provisional register. The change is visible on `code_o` after the clock edge that samples the level that ends the pulse. If k is 0 or greater than 31, the provisional register is not changed.
- R6: A long high pulse after k mid pulses, with 1 <= k <= 5, blows fuse bit k-1 (weight 2^(k-1)). Any other k, apart from 32, blows nothing.
- R7: `code_o` is the bitwise OR of the fuse bits and the provisional register.
- R8: A zero level clears the provisional register and the sequence state at the edge that samples it. Fuse bits and the lock are kept.
- R9: A blown fuse bit never returns to 0.
- R10: A long high pulse after 32 mid pulses blows the lock fuse and raises `locked_o`. After that, no sequence changes the provisional register or any fuse.
- R11: If a long high pulse that closes an address goes straight to zero, its fuse is still blown. If a short trial pulse goes straight to zero, its value is discarded.
- R12: Time spent at the low level between pulses, however long, does not change the sequence state.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Timebase clock; one cycle is one tick |
| rst_ni | input | 1 | Asynchronous active-low reset |
| level_i | input | 2 | Quantized supply level code |
| code_o | output | 5 | Effective calibration code |
| locked_o | output | 1 | Lock fuse is blown |

## Verification
Two actions can fall on the same clock edge: the decoding of a pulse that has just ended, and the clear caused by the supply reaching zero. The bench provokes this by driving a high pulse straight to zero, with no low cycle in between. It samples the outputs at the edge where zero is first seen. At that edge a closing long pulse must already show its fuse bit in the code. A closing short trial pulse must leave the code without the trial value. A second collision is checked as well: once the lock is in place, later blow attempts must leave the fuses unchanged when the supply clears.

// File: rtl/sup_prog_pkg.sv
package sup_prog_pkg;

    typedef enum logic [1:0] {
        LV_ZERO = 2'd0,
        LV_LOW  = 2'd1,
        LV_MID  = 2'd2,
        LV_HIGH = 2'd3
    } level_e;

    typedef enum logic [1:0] {
        EV_MID   = 2'd0,
        EV_SHORT = 2'd1,
        EV_LONG  = 2'd2,
        EV_BAD   = 2'd3
    } pulse_kind_e;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_KEY1 = 2'd1,
        ST_KEY2 = 2'd2,
        ST_ADDR = 2'd3
    } seq_state_e;

endpackage

// File: rtl/pp_pulse_meter.sv
module pp_pulse_meter
    import sup_prog_pkg::*;
#(
    parameter int MIN_TICKS  = 4,
    parameter int LONG_TICKS = 16
) (
    input  logic        clk_i,
    input  logic        rst_ni,
    input  level_e      level_i,
    output logic        evt_valid_o,
    output pulse_kind_e evt_kind_o,
    output logic        zero_o
);
    localparam int RUN_W = $clog2(LONG_TICKS + 1);
    localparam logic [RUN_W-1:0] RUN_MAX = RUN_W'(LONG_TICKS);
    localparam logic [RUN_W-1:0] RUN_MIN = RUN_W'(MIN_TICKS);

    typedef struct packed {
        level_e           last;
        logic [RUN_W-1:0] run;
    } meter_s;

    meter_s meter_d, meter_q;

    always_comb begin
        meter_d      = meter_q;
        meter_d.last = level_i;
        if (level_i == meter_q.last) begin
            if (meter_q.run != RUN_MAX) meter_d.run = meter_q.run + RUN_W'(1);
        end else begin
            meter_d.run = RUN_W'(1);
        end

        evt_valid_o = (level_i != meter_q.last) &&
                      (meter_q.last == LV_MID || meter_q.last == LV_HIGH);
        if (meter_q.run < RUN_MIN)            evt_kind_o = EV_BAD;
        else if (meter_q.last == LV_MID)      evt_kind_o = EV_MID;
        else if (meter_q.run < RUN_MAX)       evt_kind_o = EV_SHORT;
        else                                  evt_kind_o = EV_LONG;
        zero_o = (level_i == LV_ZERO);
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) meter_q <= '{last: LV_ZERO, run: '0};
        else         meter_q <= meter_d;
    end

    // R2: a level change starts a fresh measurement of one tick
    assert_run_restart_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (level_i != meter_q.last) |=> (meter_q.run == RUN_W'(1)));

    // R12: a steady level never shortens the measured run
    assert_run_grows_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (level_i == meter_q.last) |=> (meter_q.run >= $past(meter_q.run)));

endmodule

// File: rtl/pp_seq_decoder.sv
module pp_seq_decoder
    import sup_prog_pkg::*;
#(
    parameter int CODE_W = 5,
    localparam int ADDR_W = CODE_W + 1
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              evt_valid_i,
    input  pulse_kind_e       evt_kind_i,
    input  logic              zero_i,
    input  logic              locked_i,
    output logic [CODE_W-1:0] prov_o,
    output logic              blow_o,
    output logic [ADDR_W-1:0] blow_addr_o
);
    localparam logic [ADDR_W-1:0] LOCK_ADDR = ADDR_W'(1) << CODE_W;
    localparam logic [ADDR_W-1:0] PROV_MAX  = LOCK_ADDR - ADDR_W'(1);
    localparam logic [ADDR_W-1:0] FUSE_TOP  = ADDR_W'(CODE_W);

    typedef struct packed {
        seq_state_e        st;
        logic [ADDR_W-1:0] cnt;
        logic [CODE_W-1:0] prov;
    } dec_s;

    dec_s dec_d, dec_q;
    logic addr_fuse_ok;
    logic live_evt;

    always_comb begin
        dec_d        = dec_q;
        addr_fuse_ok = ((dec_q.cnt != '0) && (dec_q.cnt <= FUSE_TOP)) ||
                       (dec_q.cnt == LOCK_ADDR);
        live_evt     = evt_valid_i && !locked_i;
        blow_o       = live_evt && (dec_q.st == ST_ADDR) &&
                       (evt_kind_i == EV_LONG) && addr_fuse_ok;
        blow_addr_o  = dec_q.cnt;

        if (zero_i) begin
            dec_d = '{st: ST_IDLE, cnt: '0, prov: '0};
        end else if (live_evt) begin
            unique case (dec_q.st)
                ST_IDLE: dec_d.st = (evt_kind_i == EV_SHORT) ? ST_KEY1 : ST_IDLE;
                ST_KEY1: dec_d.st = (evt_kind_i == EV_MID)   ? ST_KEY2 : ST_IDLE;
                ST_KEY2: begin
                    dec_d.st  = (evt_kind_i == EV_SHORT) ? ST_ADDR : ST_IDLE;
                    dec_d.cnt = '0;
                end
                ST_ADDR: begin
                    if (evt_kind_i == EV_MID) begin
                        if (dec_q.cnt != '1) dec_d.cnt = dec_q.cnt + ADDR_W'(1);
                    end else begin
                        if (evt_kind_i == EV_SHORT && dec_q.cnt != '0 &&
                            dec_q.cnt <= PROV_MAX)
                            dec_d.prov = dec_q.cnt[CODE_W-1:0];
                        dec_d.st  = ST_IDLE;
                        dec_d.cnt = '0;
                    end
                end
                default: dec_d.st = ST_IDLE;
            endcase
        end
        prov_o = dec_q.prov;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) dec_q <= '{st: ST_IDLE, cnt: '0, prov: '0};
        else         dec_q <= dec_d;
    end

    // R8: a zero level leaves the sequencer idle with an empty trial register
    assert_zero_clears_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        zero_i |=> (dec_q.st == ST_IDLE && dec_q.prov == '0));

    // R10: once locked, nothing but a zero level moves the sequencer
    assert_locked_frozen_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (locked_i && !zero_i) |=> ($stable(dec_q.prov) && $stable(dec_q.st)));

    // R4: the address only moves by one step on a mid pulse
    assert_addr_step_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (dec_q.st == ST_ADDR && !zero_i && !locked_i && evt_valid_i &&
         evt_kind_i == EV_MID && dec_q.cnt != '1)
        |=> (dec_q.cnt == $past(dec_q.cnt) + ADDR_W'(1)));

endmodule

// File: rtl/pp_fuse_bank.sv
module pp_fuse_bank #(
    parameter int CODE_W = 5,
    localparam int ADDR_W = CODE_W + 1
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              blow_i,
    input  logic [ADDR_W-1:0] blow_addr_i,
    output logic [CODE_W-1:0] fuse_o,
    output logic              lock_o
);
    localparam logic [ADDR_W-1:0] LOCK_ADDR = ADDR_W'(1) << CODE_W;

    typedef struct packed {
        logic [CODE_W-1:0] fuse;
        logic              lock;
    } fuse_s;

    fuse_s fb_d, fb_q;

    always_comb begin
        fb_d = fb_q;
        if (blow_i) begin
            if (blow_addr_i == LOCK_ADDR) fb_d.lock = 1'b1;
            for (int b = 0; b < CODE_W; b++) begin
                if (blow_addr_i == ADDR_W'(b + 1)) fb_d.fuse[b] = 1'b1;
            end
        end
        fuse_o = fb_q.fuse;
        lock_o = fb_q.lock;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) fb_q <= '{fuse: '0, lock: 1'b0};
        else         fb_q <= fb_d;
    end

    // R9: blown bits stay blown
    assert_fuse_sticky_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        1'b1 |=> ((fb_q.fuse & $past(fb_q.fuse)) == $past(fb_q.fuse)));

    // R10: the lock never releases
    assert_lock_sticky_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
        fb_q.lock |=> fb_q.lock);

    // R10: the sequencer never requests a blow once locked
    assert_no_blow_locked_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
        fb_q.lock |-> !blow_i);

endmodule

// File: rtl/sup_prog_decoder.sv
module sup_prog_decoder
    import sup_prog_pkg::*;
#(
    parameter int CODE_W     = 5,
    parameter int MIN_TICKS  = 4,
    parameter int LONG_TICKS = 16
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic [1:0]        level_i,
    output logic [CODE_W-1:0] code_o,
    output logic              locked_o
);
    localparam int ADDR_W = CODE_W + 1;

    logic              evt_valid;
    pulse_kind_e       evt_kind;
    logic              zero_seen;
    logic [CODE_W-1:0] prov;
    logic              blow;
    logic [ADDR_W-1:0] blow_addr;
    logic [CODE_W-1:0] fuse;
    logic              lock;

    pp_pulse_meter #(.MIN_TICKS(MIN_TICKS), .LONG_TICKS(LONG_TICKS)) i_meter (
        .clk_i      (clk_i),
        .rst_ni     (rst_ni),
        .level_i    (level_e'(level_i)),
        .evt_valid_o(evt_valid),
        .evt_kind_o (evt_kind),
        .zero_o     (zero_seen)
    );

    pp_seq_decoder #(.CODE_W(CODE_W)) i_seq (
        .clk_i      (clk_i),
        .rst_ni     (rst_ni),
        .evt_valid_i(evt_valid),
        .evt_kind_i (evt_kind),
        .zero_i     (zero_seen),
        .locked_i   (lock),
        .prov_o     (prov),
        .blow_o     (blow),
        .blow_addr_o(blow_addr)
    );

    pp_fuse_bank #(.CODE_W(CODE_W)) i_fuses (
        .clk_i      (clk_i),
        .rst_ni     (rst_ni),
        .blow_i     (blow),
        .blow_addr_i(blow_addr),
        .fuse_o     (fuse),
        .lock_o     (lock)
    );

    assign code_o   = fuse | prov;
    assign locked_o = lock;

    // R11: a zero level never removes a fuse contribution from the code
    assert_zero_keeps_fuse_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (level_i == 2'd0) |=> ((code_o & $past(fuse)) == $past(fuse)));

endmodule

// File: tb/test_sup_prog_decoder.sv
module test_sup_prog_decoder;
    localparam int MINT = 4;
    localparam int LONGT = 16;
    localparam int SH = 6;
    localparam int LG = 20;
    localparam logic [1:0] ZR = 2'd0, LO = 2'd1, MI = 2'd2, HI = 2'd3;

    // {clear first, long close, mid count, expected code}
    localparam logic [13:0] VECS [10] = '{
        {1'b1, 1'b0, 7'd5,  5'd5},
        {1'b0, 1'b0, 7'd17, 5'd17},
        {1'b1, 1'b0, 7'd31, 5'd31},
        {1'b0, 1'b0, 7'd0,  5'd31},
        {1'b0, 1'b0, 7'd32, 5'd31},
        {1'b1, 1'b1, 7'd3,  5'd4},
        {1'b0, 1'b0, 7'd1,  5'd5},
        {1'b1, 1'b0, 7'd2,  5'd6},
        {1'b0, 1'b1, 7'd1,  5'd7},
        {1'b1, 1'b1, 7'd7,  5'd5}
    };

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] level = LO;
    logic [4:0] code;
    logic       locked;
    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    sup_prog_decoder #(.CODE_W(5), .MIN_TICKS(MINT), .LONG_TICKS(LONGT)) i_sup_prog_decoder (
        .clk_i(clk), .rst_ni(rst_n), .level_i(level), .code_o(code), .locked_o(locked)
    );

    task automatic hold(input logic [1:0] lv, input int n);
        level = lv;
        repeat (n) @(negedge clk);
    endtask

    task automatic key_seq(input int w, input int gap);
        hold(HI, w); hold(LO, gap);
        hold(MI, w); hold(LO, gap);
        hold(HI, w); hold(LO, gap);
    endtask

    task automatic mids(input int k);
        for (int i = 0; i < k; i++) begin
            hold(MI, SH); hold(LO, 3);
        end
    endtask

    task automatic supply_cycle();
        hold(ZR, 4); hold(LO, 4);
    endtask

    task automatic chk_code(input string tag, input logic [4:0] exp);
        checks++;
        if (code !== exp) begin
            errors++;
            $display("FAIL %s: code_o=%0d expected %0d", tag, code, exp);
        end
    endtask

    task automatic chk_lock(input string tag, input logic exp);
        checks++;
        if (locked !== exp) begin
            errors++;
            $display("FAIL %s: locked_o=%0d expected %0d", tag, locked, exp);
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: run did not complete, expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        chk_code("R1 reset code", 5'd0);
        chk_lock("R1 reset lock", 1'b0);
        rst_n = 1'b1;
        hold(LO, 4);

        // table walk: R4 address counting, R5 trial, R6 fuse blow, R7 OR merge
        for (int v = 0; v < 10; v++) begin
            if (VECS[v][13]) supply_cycle();
            key_seq(SH, 3);
            mids(int'(VECS[v][11:5]));
            hold(HI, VECS[v][12] ? LG : SH);
            hold(LO, 2);
            chk_code($sformatf("R4 R5 R6 R7 vector %0d", v), VECS[v][4:0]);
        end

        // R3 / R2: a glitch high, then a broken key, must not write
        supply_cycle();
        hold(HI, 2); hold(LO, 3);
        hold(MI, SH); hold(LO, 3);
        hold(HI, SH); hold(LO, 3);
        mids(9);
        hold(HI, SH); hold(LO, 2);
        chk_code("R3 broken key ignored", 5'd5);

        // R2: a too-short mid inside the address phase aborts the sequence
        supply_cycle();
        key_seq(SH, 3);
        hold(MI, 2); hold(LO, 3);
        mids(3);
        hold(HI, SH); hold(LO, 2);
        chk_code("R2 short mid aborts", 5'd5);

        // R2: boundary widths, key at exactly MIN, closing at LONG-1 and LONG
        supply_cycle();
        key_seq(MINT, 3); mids(2);
        hold(HI, LONGT - 1); hold(LO, 2);
        chk_code("R2 LONG-1 is short trial", 5'd7);
        supply_cycle();
        chk_code("R8 zero drops trial", 5'd5);
        key_seq(MINT, 3); mids(2);
        hold(HI, LONGT); hold(LO, 2);
        chk_code("R2 LONG is blow", 5'd7);
        supply_cycle();
        chk_code("R9 blown bit survives zero", 5'd7);

        // R12: long low gaps keep the sequence alive
        key_seq(SH, 200);
        hold(LO, 150);
        mids(8);
        hold(LO, 300);
        hold(HI, SH); hold(LO, 2);
        chk_code("R12 long low gaps", 5'd15);
        supply_cycle();

        // R11: collisions with zero
        key_seq(SH, 3); mids(4);
        hold(HI, LG); hold(ZR, 1);
        chk_code("R11 blow into zero", 5'd15);
        hold(LO, 3);
        key_seq(SH, 3); mids(16);
        hold(HI, SH); hold(ZR, 1);
        chk_code("R11 trial into zero", 5'd15);
        hold(LO, 3);

        // R10: lock freezes everything
        key_seq(SH, 3); mids(16);
        hold(HI, SH); hold(LO, 2);
        chk_code("R10 trial before lock", 5'd31);
        key_seq(SH, 3); mids(32);
        hold(HI, LG); hold(LO, 2);
        chk_lock("R10 lock blown", 1'b1);
        chk_code("R10 code at lock", 5'd31);
        key_seq(SH, 3); mids(1);
        hold(HI, SH); hold(LO, 2);
        chk_code("R10 trial ignored", 5'd31);
        key_seq(SH, 3); mids(5);
        hold(HI, LG); hold(LO, 2);
        supply_cycle();
        chk_code("R10 blow ignored", 5'd15);
        chk_lock("R10 lock after zero", 1'b1);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule